// File: doc/BRIEF.md
# Branch Resolve Unit

The branch resolve unit takes one decoded jump-class instruction per cycle, together with the two operand values already read from the register file and the current program counter. The program counter counts 64-bit instruction slots. The unit works out whether a conditional branch is taken and produces the address of the next instruction. A single combinational stage evaluates the condition, selects the displacement and adds it. Its result is captured in an output register, so every answer appears exactly one clock after the instruction is presented.

The unit has two compare widths. The narrow class looks only at the low halves of the operands, and the wide class looks at the full words. It also recognises three kinds of procedure call and the return-from-program instruction. It reports these on their own outputs so that the surrounding pipeline can act on them. Encodings that are not defined, or that appear in a form the instruction set forbids, raise an illegal flag instead of producing a branch.

The unit holds no state except the output register. The captured result is an outcome code with five values: sequential, jump, call, exit and bad. Each valid instruction selects one of them, and with in_valid low the register keeps its previous value.

Top module: `bru_branch_unit`

## Requirements
- R1: The results for an instruction presented with in_valid high at a rising clock edge appear on the outputs after that edge, and out_valid is high for that one cycle. While rst_n is low, out_valid, taken, is_call, is_exit and illegal are 0, next_pc is 0 and call_kind is 0.
- R2: Opcode layout: bits [2:0] hold the class, where 3'h5 is the wide (64-bit) class and 3'h6 is the narrow (32-bit) class. Bit 3 selects a register source when it is 1. Bits [7:4] hold the operation code. Any other class value is illegal.
- R3: Operation codes 0x1 equal, 0x5 not equal, 0x2 unsigned greater, 0x3 unsigned greater-or-equal, 0xa unsigned less and 0xb unsigned less-or-equal compare the destination operand (lhs) against the source operand. Code 0x4 is taken when the AND of the two operands is nonzero.
- R4: Codes 0x6 signed greater, 0x7 signed greater-or-equal, 0xc signed less and 0xd signed less-or-equal compare the operands as two's-complement values.
- R5: The narrow class compares only bits [31:0] of each operand (sign at bit 31). The wide class compares all 64 bits.
- R6: When opcode bit 3 is 0, the source operand is the 32-bit immediate sign-extended to 64 bits, and the rhs input is ignored.
- R7: A taken branch gives next_pc = pc + 1 + the sign-extended 16-bit offset. A branch that is not taken gives next_pc = pc + 1. The sum wraps modulo 2^PC_W.
- R8: Code 0x0 always jumps and raises taken. In the wide class it uses the 16-bit offset and ignores the immediate. In the narrow class it uses the 32-bit immediate and ignores the offset.
- R9: Code 0x8 is a call, and the 4-bit source-register field gives its kind. Field 0 is a helper call by address (call_kind 0, next_pc = pc + 1, taken 0). Field 1 is a local call (call_kind 1, next_pc = pc + 1 + immediate, taken 1). Field 2 is a helper call by type id (call_kind 2, next_pc = pc + 1, taken 0).
- R10: Code 0x9 is exit. It raises is_exit with next_pc = pc + 1 and taken 0.
- R11: The following are illegal: codes 0xe and 0xf; a call or exit in the narrow class or with opcode bit 3 set; a call whose source field is above 2. An illegal instruction raises illegal only, with taken, is_call and is_exit at 0, call_kind 0 and next_pc = pc + 1.
- R12: On a cycle whose edge sees in_valid low, out_valid falls and every other output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Class, source select and operation code |
| reg_field | input | 4 | Source-register field; carries the call kind |
| offset | input | 16 | Signed branch offset in slots |
| imm | input | 32 | Signed immediate |
| lhs | input | 64 | Destination register value |
| rhs | input | 64 | Source register value |
| pc | input | PC_W | Current slot address |
| out_valid | output | 1 | Result registered this cycle |
| next_pc | output | PC_W | Next slot address |
| taken | output | 1 | Control leaves the sequential path |
| is_call | output | 1 | Instruction is a legal call |
| call_kind | output | 2 | 0 helper by address, 1 local, 2 helper by type id |
| is_exit | output | 1 | Instruction is a legal exit |
| illegal | output | 1 | Undefined or forbidden encoding |

## Verification
Call decoding and illegal-form detection act on the same opcode in the same cycle. A call or exit carrying the register-source bit, placed in the narrow class, or given a source field of 3 triggers both of them. The outputs must then show only the illegal flag with a sequential next_pc, and the call kind must not leak through. A second collision is between condition evaluation and the always-jump path. The narrow always-jump uses a nonzero offset field, and the wide one carries a large immediate. The target must come only from the field that the class selects.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam logic [2:0] CLS_WIDE   = 3'h5;
    localparam logic [2:0] CLS_NARROW = 3'h6;

    typedef enum logic [3:0] {
        JC_ALWAYS = 4'h0,
        JC_EQ     = 4'h1,
        JC_UGT    = 4'h2,
        JC_UGE    = 4'h3,
        JC_ANY    = 4'h4,
        JC_NE     = 4'h5,
        JC_SGT    = 4'h6,
        JC_SGE    = 4'h7,
        JC_CALL   = 4'h8,
        JC_EXIT   = 4'h9,
        JC_ULT    = 4'ha,
        JC_ULE    = 4'hb,
        JC_SLT    = 4'hc,
        JC_SLE    = 4'hd
    } jcode_e;

    typedef enum logic [1:0] {
        CK_HELPER_ADDR = 2'd0,
        CK_LOCAL       = 2'd1,
        CK_HELPER_TYPE = 2'd2,
        CK_RSVD        = 2'd3
    } call_kind_e;

    typedef enum logic [2:0] {
        OUT_SEQ  = 3'd0,
        OUT_JUMP = 3'd1,
        OUT_CALL = 3'd2,
        OUT_EXIT = 3'd3,
        OUT_BAD  = 3'd4
    } outcome_e;

    typedef struct packed {
        logic       narrow;
        logic       use_reg;
        logic [3:0] code;
        logic       is_cond;
        logic       is_ja;
        logic       is_call;
        logic       is_exit;
        logic [1:0] call_kind;
        logic       illegal;
    } dec_t;

endpackage

// File: rtl/bru_decode.sv
module bru_decode
    import bru_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [3:0] reg_field,
    output dec_t       dec
);

    logic [2:0] cls;
    logic       wide;
    logic       class_ok;
    logic       form_bad;

    always_comb begin
        cls         = opcode[2:0];
        wide        = (cls == CLS_WIDE);
        dec         = '0;
        dec.narrow  = (cls == CLS_NARROW);
        dec.use_reg = opcode[3];
        dec.code    = opcode[7:4];
        class_ok    = wide | dec.narrow;
        form_bad    = 1'b0;
        unique case (jcode_e'(opcode[7:4]))
            JC_ALWAYS: dec.is_ja = 1'b1;
            JC_CALL: begin
                dec.is_call   = 1'b1;
                dec.call_kind = reg_field[1:0];
                form_bad      = !wide || opcode[3] || (reg_field > 4'd2);
            end
            JC_EXIT: begin
                dec.is_exit = 1'b1;
                form_bad    = !wide || opcode[3];
            end
            JC_EQ, JC_NE, JC_UGT, JC_UGE, JC_ULT, JC_ULE,
            JC_SGT, JC_SGE, JC_SLT, JC_SLE, JC_ANY:
                dec.is_cond = 1'b1;
            default: form_bad = 1'b1;
        endcase
        dec.illegal = !class_ok || form_bad;
    end

endmodule

// File: rtl/bru_compare.sv
module bru_compare
    import bru_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              narrow,
    input  logic [3:0]        code,
    output logic              hit
);

    localparam int HALF_W = DATA_W / 2;
    localparam int N_LANE = 2;

    logic [N_LANE-1:0] eq_l;
    logic [N_LANE-1:0] ult_l;
    logic [N_LANE-1:0] slt_l;
    logic [N_LANE-1:0] any_l;

    // lane 0 compares the low half, lane 1 the full word
    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        localparam int LW = (g == 0) ? HALF_W : DATA_W;
        logic [LW-1:0] a;
        logic [LW-1:0] b;
        assign a        = lhs[LW-1:0];
        assign b        = rhs[LW-1:0];
        assign eq_l[g]  = (a == b);
        assign ult_l[g] = (a < b);
        assign slt_l[g] = ($signed(a) < $signed(b));
        assign any_l[g] = |(a & b);
    end

    logic sel;
    logic eq, ult, slt, anyb;

    always_comb begin
        sel  = !narrow;
        eq   = eq_l[sel];
        ult  = ult_l[sel];
        slt  = slt_l[sel];
        anyb = any_l[sel];
        unique case (jcode_e'(code))
            JC_EQ:   hit = eq;
            JC_NE:   hit = !eq;
            JC_UGT:  hit = !ult && !eq;
            JC_UGE:  hit = !ult;
            JC_ULT:  hit = ult;
            JC_ULE:  hit = ult || eq;
            JC_SGT:  hit = !slt && !eq;
            JC_SGE:  hit = !slt;
            JC_SLT:  hit = slt;
            JC_SLE:  hit = slt || eq;
            JC_ANY:  hit = anyb;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bru_target.sv
module bru_target #(
    parameter int PC_W   = 32,
    parameter int DISP_W = 32
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    output logic [PC_W-1:0]   seq_pc,
    output logic [PC_W-1:0]   tgt_pc
);

    assign seq_pc = pc + PC_W'(1);
    assign tgt_pc = seq_pc + PC_W'($signed(disp));

endmodule

// File: rtl/bru_branch_unit.sv
module bru_branch_unit
    import bru_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int DATA_W = 64,
    parameter int OFF_W  = 16,
    parameter int IMM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [3:0]        reg_field,
    input  logic [OFF_W-1:0]  offset,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic [PC_W-1:0]   pc,
    output logic              out_valid,
    output logic [PC_W-1:0]   next_pc,
    output logic              taken,
    output logic              is_call,
    output logic [1:0]        call_kind,
    output logic              is_exit,
    output logic              illegal
);

    localparam int DISP_W = IMM_W;

    dec_t              dec;
    logic              hit;
    logic [DATA_W-1:0] rhs_eff;
    logic [DISP_W-1:0] disp;
    logic [PC_W-1:0]   seq_pc;
    logic [PC_W-1:0]   tgt_pc;

    bru_decode u_decode (
        .opcode    (opcode),
        .reg_field (reg_field),
        .dec       (dec)
    );

    // immediate source is sign-extended to the full operand width
    assign rhs_eff = dec.use_reg ? rhs : DATA_W'($signed(imm));

    bru_compare #(.DATA_W(DATA_W)) u_compare (
        .lhs    (lhs),
        .rhs    (rhs_eff),
        .narrow (dec.narrow),
        .code   (dec.code),
        .hit    (hit)
    );

    // narrow always-jump and calls displace by the immediate
    assign disp = (dec.is_call || (dec.is_ja && dec.narrow))
                ? imm : DISP_W'($signed(offset));

    bru_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_target (
        .pc     (pc),
        .disp   (disp),
        .seq_pc (seq_pc),
        .tgt_pc (tgt_pc)
    );

    outcome_e        kind_d, kind_q;
    logic [PC_W-1:0] npc_d, npc_q;
    logic [1:0]      ck_d, ck_q;
    logic            taken_d, taken_q;
    logic            valid_q;

    always_comb begin
        if (dec.illegal)                kind_d = OUT_BAD;
        else if (dec.is_exit)           kind_d = OUT_EXIT;
        else if (dec.is_call)           kind_d = OUT_CALL;
        else if (dec.is_ja || (dec.is_cond && hit)) kind_d = OUT_JUMP;
        else                            kind_d = OUT_SEQ;

        npc_d   = seq_pc;
        ck_d    = CK_HELPER_ADDR;
        taken_d = 1'b0;
        unique case (kind_d)
            OUT_JUMP: begin
                npc_d   = tgt_pc;
                taken_d = 1'b1;
            end
            OUT_CALL: begin
                ck_d = dec.call_kind;
                if (call_kind_e'(dec.call_kind) == CK_LOCAL) begin
                    npc_d   = tgt_pc;
                    taken_d = 1'b1;
                end
            end
            OUT_SEQ, OUT_EXIT, OUT_BAD: npc_d = seq_pc;
            default: npc_d = seq_pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            kind_q  <= OUT_SEQ;
            npc_q   <= '0;
            ck_q    <= '0;
            taken_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                kind_q  <= kind_d;
                npc_q   <= npc_d;
                ck_q    <= ck_d;
                taken_q <= taken_d;
            end
        end
    end

    always_comb begin
        out_valid = valid_q;
        next_pc   = npc_q;
        taken     = taken_q;
        call_kind = ck_q;
        is_call   = 1'b0;
        is_exit   = 1'b0;
        illegal   = 1'b0;
        unique case (kind_q)
            OUT_CALL: is_call = 1'b1;
            OUT_EXIT: is_exit = 1'b1;
            OUT_BAD:  illegal = 1'b1;
            default: ;
        endcase
    end

    // R1: each accepted instruction yields a result one cycle later
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R12: idle cycles drop valid and hold the result
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(next_pc) && $stable(taken)));

    // R7: whenever control stays sequential the address is pc + 1
    p_seq_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (taken || next_pc == $past(pc) + PC_W'(1)));

    // R11: an illegal result carries no other indication
    p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!taken && !is_call && !is_exit && call_kind == 2'd0));

    // R9: a reported call never carries the reserved kind
    p_call_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_call |-> (call_kind != 2'd3));

    // R10: call and exit only come from the wide class
    p_wide_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[2:0] != CLS_WIDE) |=> (!is_exit && !is_call));

endmodule

// File: tb/bru_branch_unit_tb_top.sv
module bru_branch_unit_tb_top;

    localparam int PC_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [3:0]  reg_field = '0;
    logic [15:0] offset = '0;
    logic [31:0] imm = '0;
    logic [63:0] lhs = '0;
    logic [63:0] rhs = '0;
    logic [PC_W-1:0] pc = '0;
    logic        out_valid;
    logic [PC_W-1:0] next_pc;
    logic        taken, is_call, is_exit, illegal;
    logic [1:0]  call_kind;

    always #10 clk = ~clk;  // 50 MHz

    bru_branch_unit #(.PC_W(PC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .reg_field(reg_field), .offset(offset), .imm(imm), .lhs(lhs),
        .rhs(rhs), .pc(pc), .out_valid(out_valid), .next_pc(next_pc),
        .taken(taken), .is_call(is_call), .call_kind(call_kind),
        .is_exit(is_exit), .illegal(illegal)
    );

    typedef struct packed {
        logic [7:0]  rq;
        logic [7:0]  op;
        logic [3:0]  sf;
        logic [15:0] off;
        logic [31:0] im;
        logic [63:0] dv;
        logic [63:0] sv;
        logic [31:0] pcv;
        logic [31:0] npc;
        logic        tk;
        logic        cl;
        logic [1:0]  kd;
        logic        ex;
        logic        il;
    } vec_t;

    localparam logic [63:0] ONES = 64'hffff_ffff_ffff_ffff;
    localparam int NV = 34;
    localparam vec_t TBL [NV] = '{
        // R8 wide always-jump: offset -4, immediate ignored
        '{8'd8, 8'h05, 4'd0, 16'hfffc, 32'd1000, 64'd0, 64'd0, 32'd100, 32'd97, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
        // R8 narrow always-jump: immediate 512, offset ignored
        '{8'd8, 8'h06, 4'd0, 16'd5, 32'd512, 64'd0, 64'd0, 32'd100, 32'd613, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
        // R3 equal / not
        '{8'd3, 8'h1d, 4'd0, 16'd8, 32'd0, 64'd5, 64'd5, 32'd100, 32'd109, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
        '{8'd3, 8'h1d, 4'd0, 16'd8, 32'd0, 64'd5, 64'd6, 32'd100, 32'd101, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
        // R3 unsigned greater with all-ones
        '{8'd3, 8'h2d, 4'd0, 16'd8, 32'd0, ONES, 64'd1, 32'd100, 32'd109, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
        // R4 signed greater / less with -1 vs 1
        '{8'd4, 8'h6d, 4'd0, 16'd8, 32'd0, ONES, 64'd1, 32'd100, 32'd101, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
        '{8'd4, 8'hcd, 4'd0, 16'd8, 32'd0, ONES, 64'd1, 32'd100, 32'd109, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
        // R3 bit test
        '{8'd3, 8'h4d, 4'd0, 16'd8, 32'd0, 64'hf0, 64'h0f, 32'd100, 32'd101, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
        '{8'd3, 8'h4d, 4'd0, 16'd8, 32'd0, 64'hf0, 64'h10, 32'd100, 32'd109, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
        // R5 narrow equal ignores high halves; wide does not
        '{8'd5, 8'h1e, 4'd0, 16'd8, 32'd0, 64'h1_0000_0005, 64'h2_0000_0005, 32'd100, 32'd109, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
        '{8'd5, 8'h1d, 4'd0, 16'd8, 32'd0, 64'h1_0000_0005, 64'h2_0000_0005, 32'd100, 32'd101, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
        // R5 narrow signed sees bit 31 as sign
        '{8'd5, 8'h6e, 4'd0, 16'd8, 32'd0, 64'h8000_0000, 64'd0, 32'd100, 32'd101, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
        '{8'd4, 8'h6d, 4'd0, 16'd8, 32'd0, 64'h8000_0000, 64'd0, 32'd100, 32'd109, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
        // R6 immediate sign-extension
        '{8'd6, 8'h35, 4'd0, 16'd8, 32'hffff_ffff, ONES, 64'd0, 32'd100, 32'd109, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
        '{8'd6, 8'h35, 4'd0, 16'd8, 32'hffff_ffff, 64'hffff_ffff, ONES, 32'd100, 32'd101, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
        // R6 rhs ignored with immediate source
        '{8'd6, 8'h55, 4'd0, 16'd8, 32'd7, 64'd7, 64'd99, 32'd100, 32'd101, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
        // R3 less-or-equal, less
        '{8'd3, 8'hbd, 4'd0, 16'd8, 32'd0, 64'd3, 64'd3, 32'd100, 32'd109, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
        '{8'd3, 8'had, 4'd0, 16'd8, 32'd0, 64'd3, 64'd3, 32'd100, 32'd101, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
        // R4 signed ge, le
        '{8'd4, 8'h7d, 4'd0, 16'd8, 32'd0, 64'hffff_ffff_ffff_fffe, 64'hffff_ffff_ffff_fffe, 32'd100, 32'd109, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
        '{8'd4, 8'hdd, 4'd0, 16'd8, 32'd0, 64'hffff_ffff_ffff_fffd, 64'hffff_ffff_ffff_fffe, 32'd100, 32'd109, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
        // R9 call kinds
        '{8'd9, 8'h85, 4'd0, 16'd8, 32'd50, 64'd0, 64'd0, 32'd100, 32'd101, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
        '{8'd9, 8'h85, 4'd1, 16'd8, 32'd50, 64'd0, 64'd0, 32'd100, 32'd151, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0},
        '{8'd9, 8'h85, 4'd1, 16'd8, 32'hffff_ffec, 64'd0, 64'd0, 32'd100, 32'd81, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0},
        '{8'd9, 8'h85, 4'd2, 16'd8, 32'd50, 64'd0, 64'd0, 32'd100, 32'd101, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0},
        // R11 forbidden call / exit forms
        '{8'd11, 8'h85, 4'd3, 16'd8, 32'd50, 64'd0, 64'd0, 32'd100, 32'd101, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1},
        '{8'd11, 8'h8d, 4'd1, 16'd8, 32'd50, 64'd0, 64'd0, 32'd100, 32'd101, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1},
        '{8'd11, 8'h86, 4'd1, 16'd8, 32'd50, 64'd0, 64'd0, 32'd100, 32'd101, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1},
        // R10 exit
        '{8'd10, 8'h95, 4'd0, 16'd8, 32'd0, 64'd0, 64'd0, 32'd100, 32'd101, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0},
        '{8'd11, 8'h96, 4'd0, 16'd8, 32'd0, 64'd0, 64'd0, 32'd100, 32'd101, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1},
        // R11 undefined codes
        '{8'd11, 8'he5, 4'd0, 16'd8, 32'd0, 64'd0, 64'd0, 32'd100, 32'd101, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1},
        '{8'd11, 8'hf5, 4'd0, 16'd8, 32'd0, 64'd0, 64'd0, 32'd100, 32'd101, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1},
        // R2 foreign class with an otherwise true equal
        '{8'd2, 8'h14, 4'd0, 16'd8, 32'd0, 64'd5, 64'd5, 32'd100, 32'd101, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1},
        // R7 wrap and backward branch
        '{8'd7, 8'h05, 4'd0, 16'd0, 32'd0, 64'd0, 64'd0, 32'hffff_ffff, 32'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
        '{8'd7, 8'h5d, 4'd0, 16'hfff0, 32'd0, 64'd1, 64'd2, 32'd100, 32'd85, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0}
    };

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        string rn;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "out_valid", 64'(out_valid), 64'd0);
        chk("R1", "next_pc", 64'(next_pc), 64'd0);
        chk("R1", "flags", 64'({taken, is_call, is_exit, illegal, call_kind}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle valid", 64'(out_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            opcode    = TBL[i].op;
            reg_field = TBL[i].sf;
            offset    = TBL[i].off;
            imm       = TBL[i].im;
            lhs       = TBL[i].dv;
            rhs       = TBL[i].sv;
            pc        = TBL[i].pcv;
            in_valid  = 1'b1;
            @(negedge clk);
            rn = $sformatf("R%0d vec%0d", TBL[i].rq, i);
            chk(rn, "out_valid", 64'(out_valid), 64'd1);
            chk(rn, "next_pc", 64'(next_pc), 64'(TBL[i].npc));
            chk(rn, "taken", 64'(taken), 64'(TBL[i].tk));
            chk(rn, "is_call", 64'(is_call), 64'(TBL[i].cl));
            chk(rn, "call_kind", 64'(call_kind), 64'(TBL[i].kd));
            chk(rn, "is_exit", 64'(is_exit), 64'(TBL[i].ex));
            chk(rn, "illegal", 64'(illegal), 64'(TBL[i].il));
        end

        // R12: idle cycle with different inputs holds the last result
        in_valid = 1'b0;
        opcode   = 8'h05;
        offset   = 16'd300;
        pc       = 32'd7;
        @(negedge clk);
        chk("R12", "out_valid", 64'(out_valid), 64'd0);
        chk("R12", "next_pc", 64'(next_pc), 64'd85);
        chk("R12", "taken", 64'(taken), 64'd1);

        // R1: back-to-back instructions each land one cycle later
        in_valid = 1'b1;
        opcode   = 8'h95;
        pc       = 32'd40;
        @(negedge clk);
        chk("R1", "b2b exit", 64'(is_exit), 64'd1);
        opcode   = 8'h05;
        offset   = 16'd2;
        @(negedge clk);
        chk("R1", "b2b jump", 64'(next_pc), 64'd43);
        chk("R1", "b2b exit cleared", 64'(is_exit), 64'd0);

        // R1: reset in mid-stream clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "reset valid", 64'(out_valid), 64'd0);
        chk("R1", "reset pc", 64'(next_pc), 64'd0);
        in_valid = 1'b0;
        finish_run();
    end

endmodule